// File: doc/BRIEF.md
# Masked Component Register File

This block holds a small set of 32-bit component registers: capability headers, error-reporting registers and the registers of one host-managed memory decoder. Software reaches them through a simple word-addressed read/write port. Each register carries a fixed per-bit write mask. On a write, the bits the mask leaves open take the new data and every other bit keeps the value it already had. This makes read-only and reserved bits immune to software writes.

Writes to the decoder control word are not stored as written. The committed status bit is made to follow the commit request bit, and the error bit is always cleared. The block also drives two things straight out of that register: the committed status, and the interleave granularity in bytes.

Parameters select the component kind, which decides which capability headers and decoder registers exist. They also select whether the component is a port or an endpoint, and how many decoders the capability word advertises. Only 4-byte accesses are served. A wide (8-byte) read returns zero, and a wide write changes nothing.

Top module: `masked_reg_block`

## Requirements
- R1: After reset, word 8 reads 0, words 9 and 10 read 0x0001CFFF, word 11 reads 0, word 12 reads 0x0000007F, word 13 reads 0x00000200, and decoder words 17 to 24 read 0.
- R2: Word 0 reads {arraySize[31:24], 4'h1 at [23:20], 4'h1 at [19:16], 16'h0001}. arraySize is 2, 3 or 5 for component kind 0, 1 or 2. Headers are written as id[15:0], version[19:16] and byte pointer[31:20]. Word 1 is (2,2,0x20) and word 2 is (4,2,0x38). Word 3 is (5,1,0x40) for kind 1 and above. Words 4 and 5 are (6,1,0x60) and (8,1,0x70) for kind 2 only.
- R3: A 4-byte write to a mapped word stores (data & mask) | (old & ~mask). The masks are 0x1CFFF for words 8 to 10 and 0x7F for words 11 and 12. Word 17 has mask 0x3. Words 18 and 20 have mask 0xF0000000, and words 19, 21 and 24 have mask all ones. Word 22 has mask 0x13FF. All header and capability words have mask 0.
- R4: A write to decoder control (word 22) whose merged bit 9 (commit) is 1 stores bit 10 (committed) as 1 and bit 11 (error) as 0.
- R5: A write to word 22 whose merged bit 9 is 0 stores bits 10 and 11 as 0.
- R6: When accWide is 1, a read returns 0 with rdValid set, and a write leaves every register unchanged.
- R7: Words that are not mapped for the chosen kind read 0 and ignore writes. This includes 6, 7, 14, 15, 25 to 31, and the decoder words when kind is 0.
- R8: Read data and rdValid appear on the clock edge after the read request. A read in the same cycle as a write to the same word returns the value from before the write.
- R9: Word 16 reads {the decoder-count code at [3:0], target count 1 at [7:4], bit 8 = 1, bit 9 = 1}. The code is 0 to 5 for 1, 2, 4, 6, 8 or 10 decoders.
- R10: The write mask of word 23 is 0xF0000000 for an endpoint (PORT_TYPE 0) and all ones for a port.
- R11: granBytes equals 256 shifted left by word 22 bits [3:0]. decCommitted equals word 22 bit 10.
- R12: Reset restores every register to its initial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read request |
| wrEn | input | 1 | Single-cycle write strobe |
| accWide | input | 1 | Access is 8 bytes wide (not served) |
| addr | input | 5 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| decCommitted | output | 1 | Decoder committed status |
| granBytes | output | 32 | Interleave granularity in bytes |

## Verification
The bench builds the block with COMP_KIND 1, PORT_TYPE 0 and DEC_COUNT 6. With these values the decoder words exist while the extra headers 4 and 5 stay unmapped, so one build covers both mapped and unmapped decoder-era words. The endpoint mask on target-list-low is exercised, and the nonzero decoder-count code 3 is visible. All-ones, all-zeros and alternating write patterns go through every word. The commit and uncommit paths of word 22 run with several granularity codes.

// File: rtl/mreg_pkg.sv
package mreg_pkg;
  parameter int REG_AW = 5;
  localparam int NREG = 1 << REG_AW;
  localparam int DW = 32;

  localparam int IDX_TOP   = 0;
  localparam int IDX_DCAP  = 16;
  localparam int IDX_DCTRL = 22;
  localparam int BIT_COMMIT    = 9;
  localparam int BIT_COMMITTED = 10;
  localparam int BIT_ERR       = 11;

  typedef struct packed {
    logic              wrStb;
    logic              rdStb;
    logic              rdZero;
    logic              ctrlWr;
    logic [REG_AW-1:0] idx;
  } strobe_t;

  function automatic logic [3:0] decCountEnc(input int n);
    case (n)
      2:  return 4'd1;
      4:  return 4'd2;
      6:  return 4'd3;
      8:  return 4'd4;
      10: return 4'd5;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] arraySizeOf(input int kind);
    return (kind >= 2) ? 8'd5 : (kind == 1) ? 8'd3 : 8'd2;
  endfunction

  function automatic logic [31:0] hdr(input int id, input int ver, input int ptr);
    return 32'(id) | (32'(ver) << 16) | (32'(ptr) << 20);
  endfunction

  function automatic logic [31:0] maskOf(input int idx, input int kind, input int portType);
    case (idx)
      8, 9, 10: return 32'h0001_CFFF;
      11, 12:   return 32'h0000_007F;
      17:       return (kind >= 1) ? 32'h3 : 32'h0;
      18, 20:   return (kind >= 1) ? 32'hF000_0000 : 32'h0;
      19, 21, 24: return (kind >= 1) ? 32'hFFFF_FFFF : 32'h0;
      22:       return (kind >= 1) ? 32'h0000_13FF : 32'h0;
      23:       return (kind >= 1) ? ((portType != 0) ? 32'hFFFF_FFFF : 32'hF000_0000) : 32'h0;
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] resetOf(input int idx, input int kind, input int decCount);
    case (idx)
      0:      return (32'(arraySizeOf(kind)) << 24) | 32'h0011_0001;
      1:      return hdr(2, 2, 'h20);
      2:      return hdr(4, 2, 'h38);
      3:      return (kind >= 1) ? hdr(5, 1, 'h40) : 32'h0;
      4:      return (kind >= 2) ? hdr(6, 1, 'h60) : 32'h0;
      5:      return (kind >= 2) ? hdr(8, 1, 'h70) : 32'h0;
      9, 10:  return 32'h0001_CFFF;
      12:     return 32'h0000_007F;
      13:     return 32'h0000_0200;
      16:     return (kind >= 1) ? (32'(decCountEnc(decCount)) | 32'h0000_0310) : 32'h0;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/mreg_ctrl.sv
module mreg_ctrl
  import mreg_pkg::*;
#(
  parameter int COMP_KIND = 1
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              accWide,
  input  logic [REG_AW-1:0] addr,
  output strobe_t           stb
);
  localparam logic HAS_DEC = (COMP_KIND >= 1);

  always_comb begin
    stb.idx    = addr;
    stb.wrStb  = wrEn && !accWide;
    stb.rdStb  = rdEn && !accWide;
    stb.rdZero = rdEn && accWide;
    stb.ctrlWr = HAS_DEC && wrEn && !accWide && (addr == REG_AW'(IDX_DCTRL));
  end
endmodule

// File: rtl/mreg_datapath.sv
module mreg_datapath
  import mreg_pkg::*;
#(
  parameter int COMP_KIND = 1,
  parameter int PORT_TYPE = 0,
  parameter int DEC_COUNT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          decCommitted,
  output logic [DW-1:0] granBytes
);
  logic [DW-1:0] regQ [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = maskOf(i, COMP_KIND, PORT_TYPE);
    localparam logic [DW-1:0] INIT = resetOf(i, COMP_KIND, DEC_COUNT);
    if (MASK == '0) begin : g_ro
      assign regQ[i] = INIT;
    end else begin : g_rw
      logic [DW-1:0] q;
      logic [DW-1:0] merged;
      if (i == IDX_DCTRL) begin : g_commit
        always_comb begin
          merged = (wrData & MASK) | (q & ~MASK);
          merged[BIT_COMMITTED] = merged[BIT_COMMIT];
          merged[BIT_ERR] = 1'b0;
        end
      end else begin : g_plain
        assign merged = (wrData & MASK) | (q & ~MASK);
      end
      always_ff @(posedge clk) begin
        if (!rstN)
          q <= INIT;
        else if (stb.wrStb && (stb.idx == REG_AW'(i)))
          q <= merged;
      end
      assign regQ[i] = q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= stb.rdStb ? regQ[stb.idx] : '0;
      rdValid <= stb.rdStb || stb.rdZero;
    end
  end

  logic unusedCtrl;
  assign unusedCtrl   = stb.ctrlWr;
  assign decCommitted = regQ[IDX_DCTRL][BIT_COMMITTED];
  assign granBytes    = 32'd256 << regQ[IDX_DCTRL][3:0];
endmodule

// File: rtl/masked_reg_block.sv
module masked_reg_block
  import mreg_pkg::*;
#(
  parameter int COMP_KIND = 1,
  parameter int PORT_TYPE = 0,
  parameter int DEC_COUNT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              accWide,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wrData,
  output logic [DW-1:0]     rdData,
  output logic              rdValid,
  output logic              decCommitted,
  output logic [DW-1:0]     granBytes
);
  strobe_t stb;

  mreg_ctrl #(.COMP_KIND(COMP_KIND)) u_ctrl (
    .rdEn(rdEn), .wrEn(wrEn), .accWide(accWide), .addr(addr), .stb(stb)
  );

  mreg_datapath #(
    .COMP_KIND(COMP_KIND), .PORT_TYPE(PORT_TYPE), .DEC_COUNT(DEC_COUNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid),
    .decCommitted(decCommitted), .granBytes(granBytes)
  );
endmodule

// File: rtl/mreg_checker.sv
module mreg_checker
  import mreg_pkg::*;
#(
  parameter int COMP_KIND = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              wrEn,
  input logic              accWide,
  input logic [REG_AW-1:0] addr,
  input logic [DW-1:0]     wrData,
  input logic [DW-1:0]     rdData,
  input logic              rdValid,
  input logic              decCommitted,
  input logic [DW-1:0]     granBytes
);
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid); // R8
  AST_WIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && accWide) |=> (rdData == '0)); // R6
  AST_WIDE_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accWide) |=> ($stable(decCommitted) && $stable(granBytes))); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !accWide && addr == REG_AW'(7)) |=> (rdData == '0)); // R7
  AST_COMMIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (COMP_KIND >= 1 && wrEn && !accWide && addr == REG_AW'(IDX_DCTRL))
      |=> (decCommitted == $past(wrData[BIT_COMMIT]))); // R4
  AST_GRAN_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(granBytes) == 1); // R11
endmodule

bind masked_reg_block mreg_checker #(.COMP_KIND(COMP_KIND)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .accWide(accWide),
  .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
  .decCommitted(decCommitted), .granBytes(granBytes)
);

// File: tb/masked_reg_block_bench.sv
`timescale 1ns/1ps
module masked_reg_block_bench;
  logic clk = 0, rstN = 0, rdEn = 0, wrEn = 0, accWide = 0;
  logic [4:0] addr = '0;
  logic [31:0] wrData = '0, rdData, granBytes;
  logic rdValid, decCommitted;
  int total = 0, fails = 0;
  bit running = 0;
  logic [31:0] mdl [32];
  logic [31:0] msk [32];

  always #4 clk = ~clk;

  masked_reg_block #(.COMP_KIND(1), .PORT_TYPE(0), .DEC_COUNT(6)) u_masked_reg_block (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .accWide(accWide),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .decCommitted(decCommitted), .granBytes(granBytes)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 32; i++) begin mdl[i] = 0; msk[i] = 0; end
    mdl[0] = 32'h0311_0001; mdl[1] = 32'h0202_0002;   // R2
    mdl[2] = 32'h0382_0004; mdl[3] = 32'h0401_0005;
    mdl[9] = 32'h1CFFF; mdl[10] = 32'h1CFFF; mdl[12] = 32'h7F; mdl[13] = 32'h200; // R1
    mdl[16] = 32'h313;                                 // R9: count 6 -> code 3
    msk[8] = 32'h1CFFF; msk[9] = 32'h1CFFF; msk[10] = 32'h1CFFF;
    msk[11] = 32'h7F; msk[12] = 32'h7F; msk[17] = 32'h3;
    msk[18] = 32'hF000_0000; msk[20] = 32'hF000_0000;
    msk[19] = '1; msk[21] = '1; msk[24] = '1; msk[22] = 32'h13FF;
    msk[23] = 32'hF000_0000;                           // R10 endpoint
  endtask

  function automatic string tagOf(input int a);
    if (a == 0 || (a >= 1 && a <= 5)) return "R2";
    if (a == 16) return "R9";
    if (a == 23) return "R10";
    if (a == 6 || a == 7 || a == 14 || a == 15 || a >= 25 || a == 4 || a == 5) return "R7";
    return "R3";
  endfunction

  task automatic doWrite(input int a, input logic [31:0] d, input bit wide);
    logic [31:0] v;
    @(negedge clk); wrEn = 1; addr = a[4:0]; wrData = d; accWide = wide;
    @(posedge clk); #1; wrEn = 0; accWide = 0;
    if (!wide) begin
      v = (d & msk[a]) | (mdl[a] & ~msk[a]);
      if (a == 22) begin v[10] = v[9]; v[11] = 1'b0; end
      mdl[a] = v;
    end
  endtask

  task automatic doRead(input int a, input bit wide, input string req);
    logic [31:0] exp;
    exp = wide ? 32'h0 : mdl[a];
    @(negedge clk); rdEn = 1; addr = a[4:0]; accWide = wide;
    @(posedge clk); #1; rdEn = 0; accWide = 0;
    @(negedge clk);
    chk({req, " valid"}, {31'b0, rdValid}, 32'h1);
    chk(req, rdData, exp);
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < 32; a++) doRead(a, 0, (req == "") ? tagOf(a) : req);
  endtask

  always @(negedge clk) if (running && rstN) begin
    chk("R11 committed", {31'b0, decCommitted}, {31'b0, mdl[22][10]});
    chk("R11 gran", granBytes, 32'd256 << mdl[22][3:0]);
  end

  initial begin
    #1_600_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1; running = 1;
    readAll("R1");
    for (int a = 0; a < 32; a++) doWrite(a, 32'hFFFF_FFFF, 0);
    readAll("");
    for (int a = 0; a < 32; a++) doWrite(a, 32'h0, 0);
    readAll("");
    for (int a = 0; a < 32; a++) doWrite(a, 32'h5A5A_A5A5 ^ a, 0);
    readAll("R3");
    // R4 commit with granularity code 4, error bit attempted
    doWrite(22, 32'h0000_0A04, 0);
    doRead(22, 0, "R4");
    chk("R4 committed", {31'b0, decCommitted}, 32'h1);
    chk("R11 4K", granBytes, 32'd4096);
    // R5 uncommit, code 3
    doWrite(22, 32'h0000_0803, 0);
    doRead(22, 0, "R5");
    chk("R5 committed", {31'b0, decCommitted}, 32'h0);
    // R6 wide write discarded, wide read zero
    doWrite(22, 32'h0000_0206, 1);
    doRead(22, 0, "R6 wide write");
    doWrite(12, 32'h0, 1);
    doRead(12, 0, "R6 wide write");
    doRead(0, 1, "R6 wide read");
    // R7 unmapped writes ignored
    doWrite(7, 32'hDEAD_BEEF, 0);
    doRead(7, 0, "R7");
    doWrite(4, 32'hDEAD_BEEF, 0);
    doRead(4, 0, "R7");
    // R8 read and write together returns old value
    @(negedge clk); rdEn = 1; wrEn = 1; addr = 5'd17; wrData = 32'h3;
    begin
      logic [31:0] old;
      old = mdl[17];
      @(posedge clk); #1; rdEn = 0; wrEn = 0;
      mdl[17] = 32'h3;
      @(negedge clk);
      chk("R8 old value", rdData, old);
      @(negedge clk);
      chk("R8 valid drops", {31'b0, rdValid}, 32'h0);
    end
    doRead(17, 0, "R8 new value");
    // R12 reset restores
    doWrite(22, 32'h0000_0201, 0);
    @(negedge clk); rstN = 0; modelReset();
    @(negedge clk); @(negedge clk); rstN = 1;
    readAll("R12");
    running = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule